// File: doc/BRIEF.md
# SM3 Message-Expansion Partial-Word Unit

This unit performs one step of the SM3 hash message-expansion schedule on 128-bit SIMD operands. Each operand holds four 32-bit lanes. Lane i occupies bits 32i+31 down to 32i. The three operands are an accumulator (whose register the result overwrites), a second operand B and a third operand C. Each lane of C is rotated left on its own. The rotated C is combined with B into an intermediate vector T, and T is folded into the accumulator. Lane 0 of T also yields a 32-bit correction word, which is mixed into the top lane only.

The datapath is pure logic followed by one register stage. A result with its valid flag appears exactly one clock after the operands are presented with `in_valid`. Latency and logic depth do not depend on the operand values. An execution pipeline uses it by driving the three source operands and a valid strobe, then writing `res_out` back to the accumulator register when `out_valid` is high.

Top module: `sm3w2_unit`

## Requirements
- R1: Each 32-bit lane of C (lane i = bits 32i+31:32i) is rotated circularly left by 7 bits inside that lane, with no bit crossing into another lane. When A and B are zero, result lanes 0 to 2 equal the rotated C lanes.
- R2: The intermediate T equals B XOR the lane-wise rotated C. When A is zero, result lanes 0 to 2 equal the matching lanes of T.
- R3: Result lanes 0, 1 and 2 equal the accumulator lanes XOR the matching lanes of T.
- R4: The result top lane (bits 127:96) equals accumulator lane 3 XOR T lane 3 XOR W. Here W = P(rotl(T lane 0, 15)) and P(x) = x XOR rotl(x,15) XOR rotl(x,23).
- R5: `out_valid` is high in a cycle exactly when `in_valid` was high on the previous clock edge outside reset. The latency is one cycle for every operand pattern, and back-to-back inputs produce back-to-back results.
- R6: A synchronous active-high `rst` drives `out_valid` low on the next clock edge, even when `in_valid` is high on that edge.
- R7: While no new operands are accepted, `res_out` keeps the last computed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on the inputs are valid this cycle |
| acc_in | input | 128 | Accumulator operand A, four 32-bit lanes |
| src_b | input | 128 | Second operand B |
| src_c | input | 128 | Third operand C, rotated per lane |
| out_valid | output | 1 | Registered result is valid |
| res_out | output | 128 | Registered result |

## Verification
The assertions check on every cycle that the valid flag follows the input strobe by exactly one cycle and that reset clears it. They also check that the result holds between accepted operands, and that each registered result matches the lane and correction formula applied to the operands captured one cycle earlier. Only the bench scenarios can show that the rotation amounts and lane positions are correct bit by bit. The bench walks a single set bit through every position of each operand and also streams pseudo-random vectors back to back. It shows that reset wins over a simultaneous strobe, and that the output holds through idle gaps.

// File: rtl/sm3w2_pkg.sv
package sm3w2_pkg;

    parameter int unsigned LANE_W = 32;
    parameter int unsigned LANES  = 4;
    localparam int unsigned DATA_W = LANE_W * LANES;
    localparam int unsigned TOP_LN = LANES - 1;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [LANES-1:0] vec_t;

    typedef struct packed {
        logic vld;
        vec_t data;
    } stage_t;

    // Circular left rotation within one lane.
    function automatic lane_t rotl(input lane_t x, input int unsigned n);
        int unsigned k;
        k = n % LANE_W;
        if (k == 0) return x;
        return (x << k) | (x >> (LANE_W - k));
    endfunction

    // Three-term diffusion used for the correction word.
    function automatic lane_t mix3(input lane_t x, input int unsigned ra, input int unsigned rb);
        return x ^ rotl(x, ra) ^ rotl(x, rb);
    endfunction

endpackage

// File: rtl/sm3w2_lane_rot.sv
module sm3w2_lane_rot
    import sm3w2_pkg::*;
#(
    parameter int unsigned AMOUNT = 7
) (
    input  vec_t din,
    output vec_t dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g] = rotl(din[g], AMOUNT);
    end
endmodule

// File: rtl/sm3w2_corr.sv
module sm3w2_corr
    import sm3w2_pkg::*;
#(
    parameter int unsigned PRE_ROT = 15,
    parameter int unsigned MIX_A   = 15,
    parameter int unsigned MIX_B   = 23
) (
    input  lane_t seed,
    output lane_t word
);
    lane_t pre;
    assign pre  = rotl(seed, PRE_ROT);
    assign word = mix3(pre, MIX_A, MIX_B);
endmodule

// File: rtl/sm3w2_stage.sv
module sm3w2_stage
    import sm3w2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  vec_t d,
    output logic q_vld,
    output vec_t q
);
    stage_t r;

    always_ff @(posedge clk) begin
        if (rst) begin
            r.vld <= 1'b0;
        end else begin
            r.vld <= load;
            if (load) r.data <= d;
        end
    end

    assign q_vld = r.vld;
    assign q     = r.data;
endmodule

// File: rtl/sm3w2_unit.sv
module sm3w2_unit
    import sm3w2_pkg::*;
#(
    parameter int unsigned ROT_C = 7,
    parameter int unsigned ROT_T = 15,
    parameter int unsigned MIX_A = 15,
    parameter int unsigned MIX_B = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_c,
    output logic              out_valid,
    output logic [DATA_W-1:0] res_out
);
    vec_t a_v, b_v, c_v;
    vec_t c_rot, t_vec, comb_res, q_res;
    lane_t corr;

    assign a_v = vec_t'(acc_in);
    assign b_v = vec_t'(src_b);
    assign c_v = vec_t'(src_c);

    sm3w2_lane_rot #(.AMOUNT(ROT_C)) u_rot (
        .din  (c_v),
        .dout (c_rot)
    );

    assign t_vec = b_v ^ c_rot;

    sm3w2_corr #(.PRE_ROT(ROT_T), .MIX_A(MIX_A), .MIX_B(MIX_B)) u_corr (
        .seed (t_vec[0]),
        .word (corr)
    );

    always_comb begin
        comb_res = a_v ^ t_vec;
        comb_res[TOP_LN] = comb_res[TOP_LN] ^ corr;
    end

    sm3w2_stage u_stage (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .d     (comb_res),
        .q_vld (out_valid),
        .q     (q_res)
    );

    assign res_out = DATA_W'(q_res);
endmodule

// File: rtl/sm3w2_checker.sv
module sm3w2_checker
    import sm3w2_pkg::*;
#(
    parameter int unsigned ROT_C = 7,
    parameter int unsigned ROT_T = 15,
    parameter int unsigned MIX_A = 15,
    parameter int unsigned MIX_B = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] src_c,
    input logic              out_valid,
    input logic [DATA_W-1:0] res_out
);
    localparam int unsigned LOW_W = LANE_W * TOP_LN;

    vec_t  a_v, b_v, c_v, t_exp, r_exp;
    lane_t w_exp;
    logic  rst_q;
    logic  loaded;

    always_comb begin
        a_v = vec_t'(acc_in);
        b_v = vec_t'(src_b);
        c_v = vec_t'(src_c);
        for (int i = 0; i < LANES; i++) t_exp[i] = b_v[i] ^ rotl(c_v[i], ROT_C);
        w_exp = mix3(rotl(t_exp[0], ROT_T), MIX_A, MIX_B);
        r_exp = a_v ^ t_exp;
        r_exp[TOP_LN] = r_exp[TOP_LN] ^ w_exp;
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)           loaded <= 1'b0;
        else if (in_valid) loaded <= 1'b1;
        if (rst_q === 1'b1) begin
            a_r6_reset_clears: assert (!out_valid);
        end
    end

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (loaded && !in_valid) |=> $stable(res_out));

    a_r3_low_lanes: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_out[LOW_W-1:0] == $past(r_exp[TOP_LN-1:0]));

    a_r4_top_lane: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_out[DATA_W-1:LOW_W] == $past(r_exp[TOP_LN]));

endmodule

bind sm3w2_unit sm3w2_checker #(
    .ROT_C (ROT_C),
    .ROT_T (ROT_T),
    .MIX_A (MIX_A),
    .MIX_B (MIX_B)
) u_chk (.*);

// File: tb/sm3w2_unit_bench.sv
module sm3w2_unit_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] acc_in = '0;
    logic [127:0] src_b = '0;
    logic [127:0] src_c = '0;
    logic         out_valid;
    logic [127:0] res_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sm3w2_unit u_sm3w2_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .acc_in    (acc_in),
        .src_b     (src_b),
        .src_c     (src_c),
        .out_valid (out_valid),
        .res_out   (res_out)
    );

    // Independent reference: rotation by doubling the word and taking a window.
    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        logic [63:0] d;
        d = {x, x} << n;
        return d[63:32];
    endfunction

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] c);
        logic [127:0] t, r;
        logic [31:0] w;
        for (int i = 0; i < 4; i++) t[32*i +: 32] = b[32*i +: 32] ^ rl(c[32*i +: 32], 7);
        r = a ^ t;
        w = rl(t[31:0], 15);
        w = w ^ rl(w, 15) ^ rl(w, 23);
        r[127:96] = r[127:96] ^ w;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input string tag, input logic [127:0] a, input logic [127:0] b,
                           input logic [127:0] c);
        logic [127:0] e;
        e = model(a, b, c);
        @(negedge clk);
        acc_in = a; src_b = b; src_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 valid", {127'd0, out_valid}, 128'd1);
        chk(tag, {32'd0, res_out[95:0]}, {32'd0, e[95:0]});
        chk("R4 top lane", {96'd0, res_out[127:96]}, {96'd0, e[127:96]});
    endtask

    logic [31:0] seed = 32'h1234_5678;
    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        return x ^ (x << 5);
    endfunction

    task automatic rnd128(output logic [127:0] v);
        for (int i = 0; i < 4; i++) begin
            seed = nxt(seed);
            v[32*i +: 32] = seed;
        end
    endtask

    initial begin
        logic [127:0] ra, rb, rc, prev_e, held;
        repeat (3) @(negedge clk);
        // Reset state
        chk("R6 reset state", {127'd0, out_valid}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 idle after reset", {127'd0, out_valid}, 128'd0);

        run_one("R3 zero operands", '0, '0, '0);

        // Walk one bit through C alone: lanes 0..2 show rotl7 per lane
        for (int k = 0; k < 128; k++) run_one("R1 rotate C", '0, '0, 128'd1 << k);
        // Walk one bit through B alone
        for (int k = 0; k < 128; k++) run_one("R2 xor B", '0, 128'd1 << k, '0);
        // Walk one bit through A alone
        for (int k = 0; k < 128; k++) run_one("R3 xor A", 128'd1 << k, '0, '0);
        // All-ones corners
        run_one("R3 all ones", '1, '1, '1);
        run_one("R2 ones B", '0, '1, '0);

        // Random vectors, one at a time
        for (int k = 0; k < 150; k++) begin
            rnd128(ra); rnd128(rb); rnd128(rc);
            run_one("R3 random", ra, rb, rc);
        end

        // Back-to-back stream: result of k checked while k+1 is driven
        prev_e = '0;
        for (int k = 0; k < 60; k++) begin
            rnd128(ra); rnd128(rb); rnd128(rc);
            @(negedge clk);
            if (k > 0) begin
                chk("R5 stream valid", {127'd0, out_valid}, 128'd1);
                chk("R3 stream data", res_out, prev_e);
            end
            acc_in = ra; src_b = rb; src_c = rc; in_valid = 1'b1;
            prev_e = model(ra, rb, rc);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 stream last valid", {127'd0, out_valid}, 128'd1);
        chk("R3 stream last data", res_out, prev_e);
        held = res_out;

        // Idle gap with changing inputs: output holds, valid stays low
        for (int k = 0; k < 5; k++) begin
            rnd128(ra);
            acc_in = ra; src_b = ~ra; src_c = ra ^ 128'h5a;
            @(negedge clk);
            chk("R5 no spurious valid", {127'd0, out_valid}, 128'd0);
            chk("R7 result holds", res_out, held);
        end

        // Reset beats a simultaneous strobe
        rnd128(ra);
        acc_in = ra; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        chk("R6 reset over strobe", {127'd0, out_valid}, 128'd0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
        chk("R6 stays low after reset", {127'd0, out_valid}, 128'd0);

        // Normal operation resumes
        rnd128(ra); rnd128(rb); rnd128(rc);
        run_one("R3 after reset", ra, rb, rc);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule